// File: doc/BRIEF.md
# Maximum-Mode Bus Command Generator

This block sits beside an 8088-class processor that runs in maximum mode. It watches the three bus status lines that the processor drives and turns them into a bus cycle type and a T-state sequence. From these it produces the address latch strobe and six active-low command strobes: memory read, memory write, advanced memory write, I/O read, I/O write and advanced I/O write. The current T-state and the cycle type are also output so that a trace can record the bus activity cycle by cycle.

A bus cycle starts when the status lines leave the passive code. The processor puts the status lines back to passive during T3, and the sequencer uses this to allow a new cycle to begin straight after T4. A low READY at the end of T3 inserts wait states, and the active strobes stay asserted through them. On each clock with no bus cycle in progress the tracker reports an idle state.

Top module: `bus_cmd_gen`

## Requirements
- R1: While reset is low and after it is released with passive status, t_state is 0 (idle), cyc_kind is 7 (passive), ale is 0 and every command strobe is 1.
- R2: Status encoding is 000 INTA, 001 IOR, 010 IOW, 011 HALT, 100 CODE, 101 MEMR, 110 MEMW, 111 PASV. When the status sampled at a rising edge is not PASV, the status sampled at the edge before it was PASV, and the tracker is idle or in T4, the next cycle is T1 (t_state 1) with ale 1 and cyc_kind set to the sampled code.
- R3: With READY high the states run T1, T2 (2), T3 (3), T4 (5). After T4 the tracker goes back to idle with cyc_kind 7, unless a new cycle starts. ale is 1 only in T1.
- R4: For CODE and MEMR cycles, mrdc_n is 0 in T2, T3 and any wait state, and is 1 in T1 and T4.
- R5: For MEMW cycles, amwc_n is 0 from T2 and mwtc_n is 0 from T3. Both stay 0 through the wait states and are 1 in T4.
- R6: For IOR cycles, iorc_n is 0 in T2, T3 and any wait state.
- R7: For IOW cycles, aiowc_n is 0 from T2 and iowc_n is 0 from T3. Both are 1 in T4.
- R8: When READY is low at the edge that ends T3 or a wait state, the next state is Tw (t_state 4) and the active strobes stay unchanged. The first edge with READY high moves the tracker to T4.
- R9: HALT and INTA cycles step through the same T-states but assert no command strobe.
- R10: A status that stays at a non-PASV code without returning to PASV starts only one cycle. After its T4 the tracker stays idle.
- R11: When a new non-PASV status appears during T4 after PASV during T3, T1 of the next cycle follows T4 directly, with no idle state between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stat | input | 3 | Processor bus status lines S2..S0 |
| ready | input | 1 | High when the addressed device is ready. Low inserts wait states |
| ale | output | 1 | Address latch strobe, high in T1 |
| mrdc_n | output | 1 | Memory read command, active low |
| amwc_n | output | 1 | Advanced memory write command, active low |
| mwtc_n | output | 1 | Memory write command, active low |
| iorc_n | output | 1 | I/O read command, active low |
| aiowc_n | output | 1 | Advanced I/O write command, active low |
| iowc_n | output | 1 | I/O write command, active low |
| t_state | output | 3 | Trace: 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4 |
| cyc_kind | output | 3 | Trace: latched cycle type, 7 when idle |

## Verification
The block has no parameters, so the bench builds the single fixed configuration. That configuration already covers every cycle type, wait-state runs of one and two clocks, cycles joined back to back through T4, and a status line that stays active without returning to passive. The expected strobe pattern for each clock comes from the cycle type and the T-state. This shows that the advanced write strobes lead the normal write strobes by exactly one clock.

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_stat,
  input  logic       ready,
  output logic       ale,
  output logic       mrdc_n,
  output logic       amwc_n,
  output logic       mwtc_n,
  output logic       iorc_n,
  output logic       aiowc_n,
  output logic       iowc_n,
  output logic [2:0] t_state,
  output logic [2:0] cyc_kind
);
  localparam logic [2:0] K_IOR  = 3'd1;
  localparam logic [2:0] K_IOW  = 3'd2;
  localparam logic [2:0] K_CODE = 3'd4;
  localparam logic [2:0] K_MEMR = 3'd5;
  localparam logic [2:0] K_MEMW = 3'd6;
  localparam logic [2:0] K_PASV = 3'd7;

  localparam logic [2:0] TS_I = 3'd0;
  localparam logic [2:0] TS_1 = 3'd1;
  localparam logic [2:0] TS_2 = 3'd2;
  localparam logic [2:0] TS_3 = 3'd3;
  localparam logic [2:0] TS_W = 3'd4;
  localparam logic [2:0] TS_4 = 3'd5;

  logic [2:0] t_q, kind_q, prev_q;
  logic       start, early, late;

  assign start = (prev_q == K_PASV) && (bus_stat != K_PASV) &&
                 ((t_q == TS_I) || (t_q == TS_4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q    <= TS_I;
      kind_q <= K_PASV;
      prev_q <= K_PASV;
    end else begin
      prev_q <= bus_stat;
      case (t_q)
        TS_I, TS_4: begin
          if (start) begin
            t_q    <= TS_1;
            kind_q <= bus_stat;
          end else begin
            t_q    <= TS_I;
            kind_q <= K_PASV;
          end
        end
        TS_1:       t_q <= TS_2;
        TS_2:       t_q <= TS_3;
        TS_3, TS_W: t_q <= ready ? TS_4 : TS_W;
        default: begin
          t_q    <= TS_I;
          kind_q <= K_PASV;
        end
      endcase
    end
  end

  assign early = (t_q == TS_2) || (t_q == TS_3) || (t_q == TS_W);
  assign late  = (t_q == TS_3) || (t_q == TS_W);

  assign ale      = (t_q == TS_1);
  assign mrdc_n   = !(early && ((kind_q == K_CODE) || (kind_q == K_MEMR)));
  assign amwc_n   = !(early && (kind_q == K_MEMW));
  assign mwtc_n   = !(late  && (kind_q == K_MEMW));
  assign iorc_n   = !(early && (kind_q == K_IOR));
  assign aiowc_n  = !(early && (kind_q == K_IOW));
  assign iowc_n   = !(late  && (kind_q == K_IOW));
  assign t_state  = t_q;
  assign cyc_kind = kind_q;

  // R3
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state == TS_1) |=> (t_state == TS_2));

  // R8
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((t_state == TS_3 || t_state == TS_W) && !ready) |=> (t_state == TS_W) && $stable(cyc_kind));

  // R5
  mem_wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mwtc_n |-> !amwc_n);

  // R7
  io_wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iowc_n |-> !aiowc_n);

  // R3
  no_cmd_in_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (mrdc_n && amwc_n && mwtc_n && iorc_n && aiowc_n && iowc_n));

  // R9
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~mrdc_n, ~amwc_n, ~mwtc_n, ~iorc_n, ~aiowc_n, ~iowc_n}) <= 2);
endmodule

// File: tb/bus_cmd_gen_tb_top.sv
`timescale 1ns/1ps
module bus_cmd_gen_tb_top;
  localparam logic [2:0] INTA = 3'd0, IOR = 3'd1, IOW = 3'd2, HALT = 3'd3,
                         CODE = 3'd4, MEMR = 3'd5, MEMW = 3'd6, PASV = 3'd7;
  localparam logic [2:0] XI = 3'd0, X1 = 3'd1, X2 = 3'd2, X3 = 3'd3, XW = 3'd4, X4 = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_stat = PASV;
  logic ready = 1'b1;
  logic ale, mrdc_n, amwc_n, mwtc_n, iorc_n, aiowc_n, iowc_n;
  logic [2:0] t_state, cyc_kind;

  always #4 clk = ~clk;

  bus_cmd_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .ready(ready),
    .ale(ale), .mrdc_n(mrdc_n), .amwc_n(amwc_n), .mwtc_n(mwtc_n),
    .iorc_n(iorc_n), .aiowc_n(aiowc_n), .iowc_n(iowc_n),
    .t_state(t_state), .cyc_kind(cyc_kind));

  typedef struct {
    int          due;
    logic [12:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] strobes(input logic [2:0] k, input logic [2:0] t);
    logic e, l;
    e = (t == X2) || (t == X3) || (t == XW);
    l = (t == X3) || (t == XW);
    return {~(e && (k == CODE || k == MEMR)), ~(e && k == MEMW), ~(l && k == MEMW),
            ~(e && k == IOR), ~(e && k == IOW), ~(l && k == IOW)};
  endfunction

  function automatic logic [12:0] observed();
    return {ale, t_state, cyc_kind, mrdc_n, amwc_n, mwtc_n, iorc_n, aiowc_n, iowc_n};
  endfunction

  task automatic step(input logic [2:0] st, input logic rd,
                      input logic [2:0] et, input logic [2:0] ek, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    bus_stat = st;
    ready    = rd;
    it.due = cyc + 1;
    it.exp = {et == X1, et, ek, strobes(ek, et)};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic bus_cycle(input logic [2:0] typ, input int waits, input logic [2:0] nxt,
                           input bit chained, input string tag);
    if (!chained) step(typ, 1'b1, X1, typ, "R2");
    step(typ, 1'b1, X2, typ, tag);
    step(PASV, 1'b1, X3, typ, tag);
    for (int w = 0; w < waits; w++) step(PASV, 1'b0, XW, typ, "R8");
    step(PASV, 1'b1, X4, typ, tag);
    if (nxt == PASV) step(PASV, 1'b1, XI, PASV, "R3");
    else             step(nxt, 1'b1, X1, nxt, "R11");
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (observed() !== it.exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got %b expected %b", it.tag, cyc, observed(), it.exp);
      end
    end
  end

  task automatic direct_check(input string tag);
    logic [12:0] e;
    e = {1'b0, XI, PASV, 6'b111111};
    n_run++;
    if (observed() !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, observed(), e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct_check("R1");
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    direct_check("R1");
    step(PASV, 1'b1, XI, PASV, "R1");

    bus_cycle(CODE, 0, PASV, 0, "R4");
    bus_cycle(MEMR, 2, PASV, 0, "R4");
    bus_cycle(MEMW, 0, PASV, 0, "R5");
    bus_cycle(MEMW, 1, PASV, 0, "R5");
    bus_cycle(IOR,  1, PASV, 0, "R6");
    bus_cycle(IOW,  0, PASV, 0, "R7");
    bus_cycle(IOW,  2, PASV, 0, "R7");
    bus_cycle(HALT, 0, PASV, 0, "R9");
    bus_cycle(INTA, 1, PASV, 0, "R9");
    step(PASV, 1'b1, XI, PASV, "R3");

    // R11: back to back through T4
    bus_cycle(MEMR, 0, MEMW, 0, "R11");
    bus_cycle(MEMW, 1, IOR, 1, "R11");
    bus_cycle(IOR, 0, PASV, 1, "R11");

    // R10: status held active, never returning to passive
    step(IOR, 1'b1, X1, IOR, "R2");
    step(IOR, 1'b1, X2, IOR, "R10");
    step(IOR, 1'b1, X3, IOR, "R10");
    step(IOR, 1'b1, X4, IOR, "R10");
    step(IOR, 1'b1, XI, PASV, "R10");
    step(IOR, 1'b1, XI, PASV, "R10");
    step(IOR, 1'b1, XI, PASV, "R10");
    step(PASV, 1'b1, XI, PASV, "R10");
    step(PASV, 1'b1, XI, PASV, "R3");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule